// File: doc/BRIEF.md
# Double-Buffered Sprite Line Writer

This block keeps two line buffers of 160 five-bit words and alternates their roles every display line. One buffer, the write side, takes sprite graphics: each incoming byte, together with a 3-bit palette value, a packing-mode bit and a starting horizontal word position, is expanded into buffer words and stored at consecutive addresses. The other buffer, the read side, feeds a downstream pixel mapper through a registered read port. Every word that port reads is cleared behind it, so the next line starts as background.

There are two packing modes. The four-word mode puts the whole palette value above each successive pair of graphics bits, starting with the top pair. The two-word mode keeps only the palette MSB and interleaves the graphics nibbles. A word whose two low bits are zero is transparent and is never stored, so sprites already drawn show through it. Byte input uses a valid/ready handshake. A line-swap request that arrives while a byte is being expanded waits until that byte has been written completely.

Top module: `sprite_line_writer`

## Requirements
- R1: After reset, `gfx_ready` is 1 and every word of both buffers reads back as 0.
- R2: With `gfx_mode`=0, an accepted byte G and palette P give four words {P[2:0],G[7:6]}, {P,G[5:4]}, {P,G[3:2]} and {P,G[1:0]}, bits shown MSB first. They go to addresses `gfx_hpos`, +1, +2 and +3 in that order.
- R3: With `gfx_mode`=1, an accepted byte gives two words, {P[2],G[3],G[2],G[7],G[6]} at `gfx_hpos` and {P[2],G[1],G[0],G[5],G[4]} at `gfx_hpos`+1.
- R4: A word whose bits [1:0] are both 0 is not written, in either mode, and the buffer word at its address keeps its earlier value.
- R5: A word whose address would be 160 or more is discarded. Addresses do not wrap, so word 0 is not disturbed.
- R6: A read with `rd_en`=1 and `rd_addr`<160 returns that word of the read-side buffer on `rd_data` one clock later, and sets the word to 0.
- R7: A `line_swap` pulse while no byte is being expanded exchanges the two buffers at that clock edge. Words written before the swap then become readable, and until the swap they are not visible on the read port.
- R8: A `line_swap` pulse that arrives while a byte is being expanded is held. All words of that byte go to the old write-side buffer, and the exchange happens at the edge that writes its last word.
- R9: After a byte is accepted, `gfx_ready` stays 0 for exactly 4 cycles in mode 0 and 2 cycles in mode 1.
- R10: A read with `rd_addr` of 160 or more returns 0 on `rd_data` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gfx_valid | input | 1 | Graphics byte present |
| gfx_byte | input | 8 | Graphics byte |
| gfx_pal | input | 3 | Palette value for this byte |
| gfx_mode | input | 1 | Packing mode: 0 = four words, 1 = two words |
| gfx_hpos | input | 8 | First word address for this byte |
| gfx_ready | output | 1 | Byte accepted when high together with gfx_valid |
| line_swap | input | 1 | Exchange the write and read buffers |
| rd_en | input | 1 | Read-and-clear request |
| rd_addr | input | 8 | Word address on the read-side buffer |
| rd_data | output | 5 | Registered read data, one cycle after rd_en |

## Verification
The buffers can only be observed through the read port, and only after a swap. A packing or transparency error therefore appears on `rd_data` as a wrong or missing word one line later, namely at the read cycle following the swap that exposes it. A buffer-select error that takes effect too early leaves part of a byte's words in the wrong buffer, and those words read as 0 after the swap. A sequencing error in the expander appears at once as a wrong number of `gfx_ready` low cycles. A failure to clear the read-side buffer appears as a non-zero value on a repeated read of the same address.

// File: rtl/slw_pkg.sv
// Package: shared constants, the packing-mode type and the word packer.
// Assumes five-bit buffer words and eight-bit graphics bytes.
package slw_pkg;
    localparam int LINE_WORDS_DEF = 160;
    localparam int WORD_W         = 5;
    localparam int PAL_W          = 3;
    localparam int GFX_W          = 8;

    typedef enum logic {
        PACK_QUAD = 1'b0,
        PACK_PAIR = 1'b1
    } pack_mode_e;

    // Build word number k of a graphics byte in the given packing mode.
    function automatic logic [WORD_W-1:0] pack_word(
        input pack_mode_e       m,
        input logic [PAL_W-1:0] p,
        input logic [GFX_W-1:0] g,
        input logic [1:0]       k
    );
        logic [WORD_W-1:0] w;
        if (m == PACK_QUAD) begin
            unique case (k)
                2'd0:    w = {p, g[7:6]};
                2'd1:    w = {p, g[5:4]};
                2'd2:    w = {p, g[3:2]};
                default: w = {p, g[1:0]};
            endcase
        end else begin
            if (k[0] == 1'b0) w = {p[2], g[3:2], g[7:6]};
            else              w = {p[2], g[1:0], g[5:4]};
        end
        return w;
    endfunction
endpackage

// File: rtl/slw_unpacker.sv
// Unpacker: latches one accepted graphics byte and emits its words, one per
// cycle, with incrementing addresses. Transparent words and words past the
// end of the line produce no write strobe.
// Assumes the downstream buffer accepts a write every cycle.
module slw_unpacker
    import slw_pkg::*;
#(
    parameter int LINE_WORDS = LINE_WORDS_DEF,
    parameter int ADDR_W     = $clog2(LINE_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [GFX_W-1:0]    in_byte,
    input  logic [PAL_W-1:0]    in_pal,
    input  logic                in_mode,
    input  logic [ADDR_W-1:0]   in_hpos,
    output logic                in_ready,
    output logic                busy,
    output logic                last,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [WORD_W-1:0]   wr_data
);
    localparam logic [ADDR_W:0] LIMIT = LINE_WORDS[ADDR_W:0];

    logic [GFX_W-1:0]  byte_q;
    logic [PAL_W-1:0]  pal_q;
    pack_mode_e        mode_q;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        idx_q;
    logic              busy_q;
    logic [ADDR_W:0]   addr_full;
    logic [1:0]        last_idx;

    // Capture a byte on handshake and step through its words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            pal_q  <= '0;
            mode_q <= PACK_QUAD;
            base_q <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            if (in_valid) begin
                byte_q <= in_byte;
                pal_q  <= in_pal;
                mode_q <= pack_mode_e'(in_mode);
                base_q <= in_hpos;
                idx_q  <= '0;
                busy_q <= 1'b1;
            end
        end else if (last) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else begin
            idx_q <= idx_q + 2'd1;
        end
    end

    // Word generation, address range test and transparency test.
    always_comb begin
        last_idx  = (mode_q == PACK_QUAD) ? 2'd3 : 2'd1;
        addr_full = {1'b0, base_q} + {{(ADDR_W-1){1'b0}}, idx_q};
        wr_data   = pack_word(mode_q, pal_q, byte_q, idx_q);
        wr_addr   = addr_full[ADDR_W-1:0];
        wr_en     = busy_q && (addr_full < LIMIT) && (wr_data[1:0] != 2'b00);
        last      = busy_q && (idx_q == last_idx);
        busy      = busy_q;
        in_ready  = !busy_q;
    end

    // Two-word mode never steps past its second word.
    assert_pair_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && mode_q == PACK_PAIR) |-> (idx_q <= 2'd1));

    // A byte accepted in four-word mode keeps the unpacker busy next cycle.
    assert_quad_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_mode) |=> (busy && !last));
endmodule

// File: rtl/slw_line_ram.sv
// Line buffer: one line of five-bit words with a write port and a
// read port whose read can also clear the addressed word.
// Assumes the write and the clear never target this buffer in the same cycle.
module slw_line_ram
    import slw_pkg::*;
#(
    parameter int LINE_WORDS = LINE_WORDS_DEF,
    parameter int ADDR_W     = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] mem [LINE_WORDS];

    // Storage: reset to background, then write or clear one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINE_WORDS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end else if (clr_en) begin
            mem[rd_addr] <= '0;
        end
    end

    // Asynchronous read, zero outside the line.
    always_comb begin
        rd_word = (int'(rd_addr) < LINE_WORDS) ? mem[rd_addr] : '0;
    end

    assert_no_clear_ram_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && clr_en));
    assert_opaque_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[1:0] != 2'b00));
    assert_write_in_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < LINE_WORDS));
endmodule

// File: rtl/slw_swap_ctrl.sv
// Swap control: holds the write-side buffer select and defers a swap
// request until the byte being unpacked has written its last word.
// Assumes line_swap is a single-cycle pulse.
module slw_swap_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic line_swap,
    input  logic unp_busy,
    input  logic unp_last,
    output logic wsel
);
    logic pending_q;
    logic do_swap;

    // A swap may happen when idle or on the last word of a byte.
    always_comb begin
        do_swap = (line_swap || pending_q) && (!unp_busy || unp_last);
    end

    // Buffer select toggle and pending-request bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wsel      <= 1'b0;
            pending_q <= 1'b0;
        end else if (do_swap) begin
            wsel      <= ~wsel;
            pending_q <= 1'b0;
        end else if (line_swap) begin
            pending_q <= 1'b1;
        end
    end

    assert_hold_mid_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (unp_busy && !unp_last) |=> $stable(wsel));
    assert_idle_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_swap && !unp_busy) |=> (wsel != $past(wsel)));
endmodule

// File: rtl/sprite_line_writer.sv
// Top: two line buffers in ping-pong, the byte unpacker on the write side and
// a registered read-and-clear port on the other side.
// Assumes one read request per cycle at most.
module sprite_line_writer
    import slw_pkg::*;
#(
    parameter int LINE_WORDS = LINE_WORDS_DEF,
    parameter int ADDR_W     = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gfx_valid,
    input  logic [7:0]        gfx_byte,
    input  logic [2:0]        gfx_pal,
    input  logic              gfx_mode,
    input  logic [ADDR_W-1:0] gfx_hpos,
    output logic              gfx_ready,
    input  logic              line_swap,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [4:0]        rd_data
);
    localparam int NBUF = 2;

    logic              unp_busy, unp_last, unp_we;
    logic [ADDR_W-1:0] unp_addr;
    logic [WORD_W-1:0] unp_data;
    logic              wsel;
    logic              rd_in_line;
    logic [WORD_W-1:0] buf_word [NBUF];
    logic [WORD_W-1:0] rd_word;

    slw_unpacker #(.LINE_WORDS(LINE_WORDS), .ADDR_W(ADDR_W)) u_unp (
        .clk(clk), .rst_n(rst_n),
        .in_valid(gfx_valid), .in_byte(gfx_byte), .in_pal(gfx_pal),
        .in_mode(gfx_mode), .in_hpos(gfx_hpos), .in_ready(gfx_ready),
        .busy(unp_busy), .last(unp_last),
        .wr_en(unp_we), .wr_addr(unp_addr), .wr_data(unp_data)
    );

    slw_swap_ctrl u_swap (
        .clk(clk), .rst_n(rst_n), .line_swap(line_swap),
        .unp_busy(unp_busy), .unp_last(unp_last), .wsel(wsel)
    );

    // Read request lies inside the line.
    always_comb rd_in_line = int'(rd_addr) < LINE_WORDS;

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        slw_line_ram #(.LINE_WORDS(LINE_WORDS), .ADDR_W(ADDR_W)) u_ram (
            .clk(clk), .rst_n(rst_n),
            .wr_en(unp_we && (wsel == b[0])),
            .wr_addr(unp_addr), .wr_data(unp_data),
            .clr_en(rd_en && rd_in_line && (wsel != b[0])),
            .rd_addr(rd_addr), .rd_word(buf_word[b])
        );
    end

    // Select the read-side buffer.
    always_comb rd_word = wsel ? buf_word[0] : buf_word[1];

    // Register read data; out-of-line reads return zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_in_line ? rd_word : '0;
    end

    assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gfx_valid && gfx_ready) |=> !gfx_ready);
    assert_out_of_line_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_in_line) |=> (rd_data == '0));
endmodule

// File: tb/tb_sprite_line_writer.sv
module tb_sprite_line_writer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gfx_valid = 1'b0;
    logic [7:0] gfx_byte = '0;
    logic [2:0] gfx_pal = '0;
    logic       gfx_mode = 1'b0;
    logic [7:0] gfx_hpos = '0;
    logic       gfx_ready;
    logic       line_swap = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [4:0] rd_data;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    sprite_line_writer dut (
        .clk(clk), .rst_n(rst_n), .gfx_valid(gfx_valid), .gfx_byte(gfx_byte),
        .gfx_pal(gfx_pal), .gfx_mode(gfx_mode), .gfx_hpos(gfx_hpos),
        .gfx_ready(gfx_ready), .line_swap(line_swap), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // {mode, pal, byte, hpos, word@hpos, @+1, @+2, @+3}
    localparam logic [39:0] VEC [6] = '{
        {1'b0, 3'd5, 8'hE4, 8'd5,   5'h17, 5'h16, 5'h15, 5'h00},
        {1'b0, 3'd2, 8'h1B, 8'd10,  5'h00, 5'h09, 5'h0A, 5'h0B},
        {1'b1, 3'd6, 8'h6C, 8'd50,  5'h1D, 5'h12, 5'h00, 5'h00},
        {1'b1, 3'd3, 8'h3C, 8'd100, 5'h00, 5'h03, 5'h00, 5'h00},
        {1'b0, 3'd7, 8'hFF, 8'd158, 5'h1F, 5'h1F, 5'h00, 5'h00},
        {1'b1, 3'd4, 8'h00, 8'd20,  5'h00, 5'h00, 5'h00, 5'h00}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Offer a byte, wait for acceptance, return the ready-low cycle count.
    task automatic send_byte(input logic m, input logic [2:0] p,
                             input logic [7:0] g, input logic [7:0] h,
                             input bit swap_mid, output int low);
        @(negedge clk);
        gfx_valid = 1'b1; gfx_mode = m; gfx_pal = p; gfx_byte = g; gfx_hpos = h;
        while (!gfx_ready) @(negedge clk);
        @(negedge clk);
        gfx_valid = 1'b0;
        low = 0;
        if (swap_mid) begin
            line_swap = 1'b1;
            low++;
            @(negedge clk);
            line_swap = 1'b0;
        end
        while (!gfx_ready) begin
            low++;
            @(negedge clk);
        end
    endtask

    task automatic do_swap();
        @(negedge clk);
        line_swap = 1'b1;
        @(negedge clk);
        line_swap = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output int v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int v, low;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of handshake and both buffers.
        check("R1 ready", int'(gfx_ready), 1);
        do_read(8'd5, v);   check("R1 buf read side", v, 0);
        do_swap();
        do_read(8'd5, v);   check("R1 buf other side", v, 0);
        do_swap();

        // Table: write one byte, swap, read four words back (R2 R3 R4 R5 R9).
        foreach (VEC[i]) begin
            logic [39:0] e = VEC[i];
            send_byte(e[39], e[38:36], e[35:28], e[27:20], 1'b0, low);
            check(e[39] ? "R9 pair-mode busy" : "R9 quad-mode busy", low, e[39] ? 2 : 4);
            do_swap();
            for (int k = 0; k < 4; k++) begin
                do_read(e[27:20] + 8'(k), v);
                check(e[39] ? "R3 word" : "R2 word", v, int'(e[19 - 5*k -: 5]));
            end
        end

        // R7: unswapped words stay hidden, then appear after a swap; R6 clear on read.
        send_byte(1'b0, 3'd3, 8'h55, 8'd120, 1'b0, low);
        do_read(8'd120, v); check("R7 hidden before swap", v, 0);
        do_swap();
        do_read(8'd120, v); check("R7 visible after swap", v, 5'h0D);
        do_read(8'd120, v); check("R6 cleared by read", v, 0);
        for (int k = 1; k < 4; k++) begin
            do_read(8'd120 + 8'(k), v); check("R6 read word", v, 5'h0D);
        end

        // R5: no wrap past the line end; R10: out-of-line read is zero.
        send_byte(1'b0, 3'd7, 8'hFF, 8'd159, 1'b0, low);
        do_swap();
        do_read(8'd159, v); check("R5 last word", v, 5'h1F);
        do_read(8'd0, v);   check("R5 no wrap word0", v, 0);
        do_read(8'd1, v);   check("R5 no wrap word1", v, 0);
        do_read(8'd200, v); check("R10 out-of-line read", v, 0);

        // R4: transparent words leave an earlier sprite intact.
        send_byte(1'b0, 3'd5, 8'hFF, 8'd70, 1'b0, low);
        send_byte(1'b0, 3'd2, 8'h30, 8'd70, 1'b0, low);
        do_swap();
        do_read(8'd70, v); check("R4 keep w0", v, 5'h17);
        do_read(8'd71, v); check("R4 overwrite w1", v, 5'h0B);
        do_read(8'd72, v); check("R4 keep w2", v, 5'h17);
        do_read(8'd73, v); check("R4 keep w3", v, 5'h17);

        // R8: swap during unpacking completes the byte into the old buffer.
        send_byte(1'b0, 3'd1, 8'h55, 8'd30, 1'b1, low);
        check("R8 busy span", low, 4);
        for (int k = 0; k < 4; k++) begin
            do_read(8'd30 + 8'(k), v); check("R8 word in old buffer", v, 5'h05);
        end

        finish_run();
    end
endmodule